// File: doc/BRIEF.md
# Translation Table Geometry Decoder

This block turns the raw contents of a set of table base registers, a command queue base register and a few identifier-width fields into ready-to-use geometry for two memory-resident tables: the device table and the collection table. For each table it gives a valid flag, the page size in bytes, an indirect (two-level) flag, the entry size in bytes, the number of entries the table can hold, the base physical address and the number of identifiers the table covers. For the command queue it gives a valid flag, the base address and the number of 32-byte commands that fit.

A decode pass starts when the unit enable input rises or when the reload strobe is pulsed. At that edge the inputs are captured, and the queue geometry is updated at once. The base registers are then examined one per clock, from index 0 upwards. Each register is routed by its type field to the device or the collection parameter set. The pass ends after the last register, or early when a selected table is marked invalid. A one-cycle done strobe marks the end of the pass. Walking the tables in memory is left to other logic.

Top module: `table_geom_decoder`

## Requirements
- R1: The page-size code in bits [9:8] of a base register selects the page size: code 0 gives 4096 bytes, code 1 gives 16384 bytes, and codes 2 and 3 both give 65536 bytes.
- R2: For a valid table whose indirect bit (bit 62) is 0, the entry count equals (size field bits [7:0] plus one) times the page size, divided by the entry size, where the entry size in bytes is bits [52:48] plus one.
- R3: For a valid table whose indirect bit is 1, the entry count equals ((size field plus one) times page size / 8) times (page size / entry size).
- R4: The base address is bits [47:12] placed at bit 12 for 4 KB and 16 KB pages. For 64 KB pages it is bits [47:16] placed at bit 16, with bits [15:12] placed at bit 48.
- R5: The type field in bits [58:56] routes a register: value 1 updates the device set and value 4 updates the collection set. An all-zero register and any other type value leave both sets unchanged.
- R6: When a routed register has its valid bit (bit 63) clear, that parameter set becomes all zero and the pass ends at that register, without examining later registers.
- R7: The device identifier count is 2 to the power (device-bits field + 1). The collection identifier count is 2 to the power (collection-bits field + 1) when the limit select is 1, and 65536 when it is 0.
- R8: On a trigger edge the queue outputs take: valid equal to bit 63 of the queue register; entries equal to (bits [7:0] + 1) × 4096 / 32; base equal to bits [51:12] placed at bit 12. An invalid queue gives zero entries and a zero base. Between triggers the queue outputs hold.
- R9: A trigger is a rising unit enable or a high reload, sampled at a clock edge. Register k is processed at the (k+2)-th edge counted from the trigger edge as the first. done is high for exactly one cycle after the edge that processes the last register or the stopping register. A new trigger during a pass restarts it from index 0. The table outputs do not change outside a pass.
- R10: After reset all outputs are zero and done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unit_en | input | 1 | Unit enable level; its rising edge starts a pass |
| reload | input | 1 | Reload strobe; starts a pass while high at an edge |
| base_regs | input | NUM_BASE*64 | Table base registers, register k at bits [64k+63:64k] |
| queue_reg | input | 64 | Command queue base register |
| dev_id_bits | input | 5 | Device identifier width minus one |
| coll_id_bits | input | 4 | Collection identifier width minus one |
| coll_id_limited | input | 1 | Selects coll_id_bits for the collection identifier count |
| dev_valid | output | 1 | Device table valid |
| dev_page_bytes | output | 17 | Device table page size in bytes |
| dev_indirect | output | 1 | Device table is two-level |
| dev_entry_bytes | output | 6 | Device table entry size in bytes |
| dev_max_entries | output | 40 | Device table entry capacity |
| dev_base | output | 52 | Device table base address |
| dev_max_ids | output | 33 | Device identifier count |
| coll_valid | output | 1 | Collection table valid |
| coll_page_bytes | output | 17 | Collection table page size in bytes |
| coll_indirect | output | 1 | Collection table is two-level |
| coll_entry_bytes | output | 6 | Collection table entry size in bytes |
| coll_max_entries | output | 40 | Collection table entry capacity |
| coll_base | output | 52 | Collection table base address |
| coll_max_ids | output | 33 | Collection identifier count |
| cq_valid | output | 1 | Command queue valid |
| cq_base | output | 52 | Command queue base address |
| cq_entries | output | 16 | Command queue capacity in commands |
| done | output | 1 | One-cycle end-of-pass strobe |

## Verification
Every cycle, the assertions check that a valid table reports one of the three legal page sizes and a power-of-two identifier count, that an invalid table reports all-zero geometry, and that the queue capacity is a non-zero multiple of 128 exactly when the queue is valid. They also check that the queue holds between triggers, that table outputs hold outside a pass, and that done is a single-cycle pulse that only follows a busy cycle. The actual arithmetic cannot be shown by a property: the capacity and address values for each page size, the routing by type, the early stop on an invalid table, and the restart of a pass interrupted by a fresh trigger. These are shown only by the bench's scenarios, where a behavioural model is compared against the outputs every clock.

// File: rtl/tgd_pkg.sv
package tgd_pkg;
   localparam int REG_W = 64;
   localparam int PGB_W = 17;
   localparam int ESZ_W = 6;
   localparam int ENT_W = 40;
   localparam int ADR_W = 52;
   localparam int IDS_W = 33;
   localparam int CQE_W = 16;

   localparam logic [2:0] KIND_DEV  = 3'd1;
   localparam logic [2:0] KIND_COLL = 3'd4;

   typedef struct packed {
      logic             valid;
      logic [PGB_W-1:0] page_bytes;
      logic             indirect;
      logic [ESZ_W-1:0] entry_bytes;
      logic [ENT_W-1:0] max_entries;
      logic [ADR_W-1:0] base;
      logic [IDS_W-1:0] max_ids;
   } geom_t;
endpackage

// File: rtl/tgd_table_calc.sv
module tgd_table_calc
   import tgd_pkg::*;
#(
   parameter int L1_LOG2 = 3
) (
   input  logic [REG_W-1:0] raw,
   input  logic [IDS_W-1:0] id_cap,
   output geom_t            geom
);
   logic [1:0]       pg_code;
   logic [4:0]       pg_log2;
   logic [8:0]       pages;
   logic [ENT_W-1:0] tot_bytes;
   logic [ESZ_W-1:0] esz;
   logic [ENT_W-1:0] flat_cnt;
   logic [ENT_W-1:0] l1_cnt;
   logic [ENT_W-1:0] per_page;
   logic [ENT_W-1:0] ind_cnt;
   logic [ADR_W-1:0] base_addr;
   logic             unused_bits;

   assign unused_bits = ^{raw[61:59], raw[55:53], raw[11:10]};

   always_comb begin
      pg_code = raw[9:8];
      unique case (pg_code)
         2'd0:    pg_log2 = 5'd12;
         2'd1:    pg_log2 = 5'd14;
         default: pg_log2 = 5'd16;
      endcase
      pages     = {1'b0, raw[7:0]} + 9'd1;
      tot_bytes = ENT_W'(pages) << pg_log2;
      esz       = {1'b0, raw[52:48]} + 6'd1;
      flat_cnt  = tot_bytes / ENT_W'(esz);
      l1_cnt    = tot_bytes >> L1_LOG2;
      per_page  = (ENT_W'(1) << pg_log2) / ENT_W'(esz);
      ind_cnt   = l1_cnt * per_page;
      if (pg_code[1])
         base_addr = {raw[15:12], raw[47:16], 16'h0000};
      else
         base_addr = {4'h0, raw[47:12], 12'h000};

      geom.valid       = raw[63];
      geom.page_bytes  = PGB_W'(1) << pg_log2;
      geom.indirect    = raw[62];
      geom.entry_bytes = esz;
      geom.max_entries = raw[62] ? ind_cnt : flat_cnt;
      geom.base        = base_addr;
      geom.max_ids     = id_cap;
   end
endmodule

// File: rtl/tgd_queue_calc.sv
module tgd_queue_calc
   import tgd_pkg::*;
#(
   parameter int CMD_LOG2  = 5,
   parameter int PAGE_LOG2 = 12
) (
   input  logic [REG_W-1:0] raw,
   output logic             q_valid,
   output logic [ADR_W-1:0] q_base,
   output logic [CQE_W-1:0] q_entries
);
   localparam int PER_PAGE_LOG2 = PAGE_LOG2 - CMD_LOG2;

   logic [8:0] pages;
   logic       unused_bits;

   assign unused_bits = ^{raw[62:52], raw[11:8]};
   assign pages       = {1'b0, raw[7:0]} + 9'd1;
   assign q_valid     = raw[63];
   assign q_entries   = raw[63] ? (CQE_W'(pages) << PER_PAGE_LOG2) : '0;
   assign q_base      = raw[63] ? {raw[51:12], 12'h000} : '0;
endmodule

// File: rtl/tgd_walk_seq.sv
module tgd_walk_seq #(
   parameter int NUM_BASE = 8,
   localparam int IDX_W   = $clog2(NUM_BASE)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig,
   input  logic             halt,
   output logic [IDX_W-1:0] idx,
   output logic             busy,
   output logic             step,
   output logic             done
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_BASE - 1);

   assign step = busy && !trig;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx  <= '0;
         busy <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (trig) begin
            idx  <= '0;
            busy <= 1'b1;
         end else if (busy) begin
            if (halt || idx == LAST) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               idx <= idx + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/table_geom_decoder.sv
module table_geom_decoder
   import tgd_pkg::*;
#(
   parameter int NUM_BASE = 8,
   parameter bit SNAPSHOT = 1'b1,
   parameter int L1_LOG2  = 3,
   parameter int CMD_LOG2 = 5
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      unit_en,
   input  logic                      reload,
   input  logic [NUM_BASE*REG_W-1:0] base_regs,
   input  logic [REG_W-1:0]          queue_reg,
   input  logic [4:0]                dev_id_bits,
   input  logic [3:0]                coll_id_bits,
   input  logic                      coll_id_limited,
   output logic                      dev_valid,
   output logic [PGB_W-1:0]          dev_page_bytes,
   output logic                      dev_indirect,
   output logic [ESZ_W-1:0]          dev_entry_bytes,
   output logic [ENT_W-1:0]          dev_max_entries,
   output logic [ADR_W-1:0]          dev_base,
   output logic [IDS_W-1:0]          dev_max_ids,
   output logic                      coll_valid,
   output logic [PGB_W-1:0]          coll_page_bytes,
   output logic                      coll_indirect,
   output logic [ESZ_W-1:0]          coll_entry_bytes,
   output logic [ENT_W-1:0]          coll_max_entries,
   output logic [ADR_W-1:0]          coll_base,
   output logic [IDS_W-1:0]          coll_max_ids,
   output logic                      cq_valid,
   output logic [ADR_W-1:0]          cq_base,
   output logic [CQE_W-1:0]          cq_entries,
   output logic                      done
);
   localparam int IDX_W  = $clog2(NUM_BASE);
   localparam int N_KIND = 2;

   if (NUM_BASE < 2 || NUM_BASE > 8) begin : g_bad_num
      $error("NUM_BASE must lie in 2..8");
   end
   if (L1_LOG2 < 0 || L1_LOG2 > 12) begin : g_bad_l1
      $error("L1_LOG2 must lie in 0..12");
   end
   if (CMD_LOG2 < 0 || CMD_LOG2 > 12) begin : g_bad_cmd
      $error("CMD_LOG2 must not exceed the 4 KB queue page");
   end

   logic                      en_q;
   logic                      trig;
   logic                      busy;
   logic                      step;
   logic                      halt;
   logic [IDX_W-1:0]          idx;
   logic [NUM_BASE*REG_W-1:0] bank_v;
   logic [4:0]                db_v;
   logic [3:0]                cb_v;
   logic                      cil_v;
   logic [REG_W-1:0]          cur_raw;
   logic [2:0]                cur_type;
   logic                      cur_live;
   logic [IDS_W-1:0]          dev_cap;
   logic [IDS_W-1:0]          coll_cap;
   logic [IDS_W-1:0]          cur_cap;
   geom_t                     cur_geom;
   geom_t                     set_q [N_KIND];
   logic                      qv_n;
   logic [ADR_W-1:0]          qb_n;
   logic [CQE_W-1:0]          qe_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= unit_en;
   end
   assign trig = (unit_en && !en_q) || reload;

   if (SNAPSHOT) begin : g_snap
      logic [NUM_BASE*REG_W-1:0] bank_q;
      logic [4:0]                db_q;
      logic [3:0]                cb_q;
      logic                      cil_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bank_q <= '0;
            db_q   <= '0;
            cb_q   <= '0;
            cil_q  <= 1'b0;
         end else if (trig) begin
            bank_q <= base_regs;
            db_q   <= dev_id_bits;
            cb_q   <= coll_id_bits;
            cil_q  <= coll_id_limited;
         end
      end
      assign bank_v = bank_q;
      assign db_v   = db_q;
      assign cb_v   = cb_q;
      assign cil_v  = cil_q;
   end else begin : g_live
      assign bank_v = base_regs;
      assign db_v   = dev_id_bits;
      assign cb_v   = coll_id_bits;
      assign cil_v  = coll_id_limited;
   end

   assign cur_raw  = bank_v[idx*REG_W +: REG_W];
   assign cur_type = cur_raw[58:56];
   assign cur_live = step && (cur_raw != '0);
   assign dev_cap  = IDS_W'(1) << ({1'b0, db_v} + 6'd1);
   assign coll_cap = cil_v ? (IDS_W'(1) << ({1'b0, cb_v} + 5'd1)) : (IDS_W'(1) << 16);
   assign cur_cap  = (cur_type == KIND_COLL) ? coll_cap : dev_cap;
   assign halt     = cur_live && !cur_raw[63] &&
                     (cur_type == KIND_DEV || cur_type == KIND_COLL);

   tgd_walk_seq #(.NUM_BASE(NUM_BASE)) seq_i (
      .clk  (clk),
      .rst_n(rst_n),
      .trig (trig),
      .halt (halt),
      .idx  (idx),
      .busy (busy),
      .step (step),
      .done (done)
   );

   tgd_table_calc #(.L1_LOG2(L1_LOG2)) calc_i (
      .raw   (cur_raw),
      .id_cap(cur_cap),
      .geom  (cur_geom)
   );

   for (genvar k = 0; k < N_KIND; k++) begin : g_kind
      localparam logic [2:0] CODE = (k == 0) ? KIND_DEV : KIND_COLL;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            set_q[k] <= '0;
         else if (cur_live && cur_type == CODE)
            set_q[k] <= cur_raw[63] ? cur_geom : '0;
      end
   end

   tgd_queue_calc #(.CMD_LOG2(CMD_LOG2), .PAGE_LOG2(12)) qcalc_i (
      .raw      (queue_reg),
      .q_valid  (qv_n),
      .q_base   (qb_n),
      .q_entries(qe_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cq_valid   <= 1'b0;
         cq_base    <= '0;
         cq_entries <= '0;
      end else if (trig) begin
         cq_valid   <= qv_n;
         cq_base    <= qb_n;
         cq_entries <= qe_n;
      end
   end

   assign dev_valid        = set_q[0].valid;
   assign dev_page_bytes   = set_q[0].page_bytes;
   assign dev_indirect     = set_q[0].indirect;
   assign dev_entry_bytes  = set_q[0].entry_bytes;
   assign dev_max_entries  = set_q[0].max_entries;
   assign dev_base         = set_q[0].base;
   assign dev_max_ids      = set_q[0].max_ids;
   assign coll_valid       = set_q[1].valid;
   assign coll_page_bytes  = set_q[1].page_bytes;
   assign coll_indirect    = set_q[1].indirect;
   assign coll_entry_bytes = set_q[1].entry_bytes;
   assign coll_max_entries = set_q[1].max_entries;
   assign coll_base        = set_q[1].base;
   assign coll_max_ids     = set_q[1].max_ids;
endmodule

// File: rtl/table_geom_chk.sv
module table_geom_chk
   import tgd_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             done,
   input logic             busy,
   input logic             trig,
   input logic             dev_valid,
   input logic [PGB_W-1:0] dev_page_bytes,
   input logic [ENT_W-1:0] dev_max_entries,
   input logic [ADR_W-1:0] dev_base,
   input logic [IDS_W-1:0] dev_max_ids,
   input logic             coll_valid,
   input logic [PGB_W-1:0] coll_page_bytes,
   input logic [ENT_W-1:0] coll_max_entries,
   input logic [ADR_W-1:0] coll_base,
   input logic [IDS_W-1:0] coll_max_ids,
   input logic             cq_valid,
   input logic [ADR_W-1:0] cq_base,
   input logic [CQE_W-1:0] cq_entries
);
   p_page_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
      dev_valid |-> (dev_page_bytes == 17'd4096 || dev_page_bytes == 17'd16384 ||
                     dev_page_bytes == 17'd65536));

   p_coll_page_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
      coll_valid |-> (coll_page_bytes == 17'd4096 || coll_page_bytes == 17'd16384 ||
                      coll_page_bytes == 17'd65536));

   p_dev_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !dev_valid |-> (dev_max_entries == '0 && dev_base == '0 &&
                      dev_max_ids == '0 && dev_page_bytes == '0));

   p_coll_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !coll_valid |-> (coll_max_entries == '0 && coll_base == '0 &&
                       coll_max_ids == '0 && coll_page_bytes == '0));

   p_dev_ids_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dev_valid |-> $countones(dev_max_ids) == 1);

   p_coll_ids_r7: assert property (@(posedge clk) disable iff (!rst_n)
      coll_valid |-> ($countones(coll_max_ids) == 1 && coll_max_ids <= 33'h10000));

   p_queue_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cq_valid |-> (cq_entries != '0 && cq_entries[6:0] == 7'd0));

   p_queue_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !cq_valid |-> (cq_entries == '0 && cq_base == '0));

   p_queue_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !trig |=> ($stable(cq_valid) && $stable(cq_base) && $stable(cq_entries)));

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy));

   p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !trig) |=> ($stable(dev_valid) && $stable(dev_base) &&
                            $stable(coll_valid) && $stable(coll_base)));
endmodule

bind table_geom_decoder table_geom_chk chk_i (.*);

// File: tb/table_geom_decoder_tb_top.sv
module table_geom_decoder_tb_top;
   logic         clk = 1'b0;
   logic         rst_n;
   logic         unit_en;
   logic         reload;
   logic [511:0] base_regs;
   logic [63:0]  queue_reg;
   logic [4:0]   dev_id_bits;
   logic [3:0]   coll_id_bits;
   logic         coll_id_limited;
   logic         dev_valid, dev_indirect, coll_valid, coll_indirect, cq_valid, done;
   logic [16:0]  dev_page_bytes, coll_page_bytes;
   logic [5:0]   dev_entry_bytes, coll_entry_bytes;
   logic [39:0]  dev_max_entries, coll_max_entries;
   logic [51:0]  dev_base, coll_base, cq_base;
   logic [32:0]  dev_max_ids, coll_max_ids;
   logic [15:0]  cq_entries;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;
   bit monitor_on = 1'b0;

   always #2 clk = ~clk;

   table_geom_decoder dut_i (
      .clk, .rst_n, .unit_en, .reload, .base_regs, .queue_reg,
      .dev_id_bits, .coll_id_bits, .coll_id_limited,
      .dev_valid, .dev_page_bytes, .dev_indirect, .dev_entry_bytes,
      .dev_max_entries, .dev_base, .dev_max_ids,
      .coll_valid, .coll_page_bytes, .coll_indirect, .coll_entry_bytes,
      .coll_max_entries, .coll_base, .coll_max_ids,
      .cq_valid, .cq_base, .cq_entries, .done
   );

   // ---------------- behavioural reference model ----------------
   longint unsigned m_valid[2], m_pg[2], m_ind[2], m_esz[2], m_ent[2], m_base[2], m_ids[2];
   longint unsigned m_cqv, m_cqb, m_cqe, m_done;
   bit              m_busy, en_prev;
   int              m_pos;
   logic [63:0]     snap[$];
   int              s_db, s_cb, s_cil;

   function automatic longint unsigned page_of(logic [1:0] c);
      if (c == 2'd0) return 4096;
      if (c == 2'd1) return 16384;
      return 65536;
   endfunction

   task automatic model_clear(int k);
      m_valid[k] = 0; m_pg[k] = 0; m_ind[k] = 0; m_esz[k] = 0;
      m_ent[k] = 0; m_base[k] = 0; m_ids[k] = 0;
   endtask

   task automatic model_apply(logic [63:0] r, output bit stop);
      int k;
      longint unsigned pg, tot, esz, a;
      stop = 0;
      if (r == 64'd0) return;
      if (r[58:56] == 3'd1) k = 0;
      else if (r[58:56] == 3'd4) k = 1;
      else return;
      if (!r[63]) begin
         model_clear(k);
         stop = 1;
         return;
      end
      pg  = page_of(r[9:8]);
      tot = (longint'(r[7:0]) + 1) * pg;
      esz = longint'(r[52:48]) + 1;
      a   = longint'(r[47:12]);
      m_valid[k] = 1; m_pg[k] = pg; m_ind[k] = r[62]; m_esz[k] = esz;
      m_ent[k]   = r[62] ? (tot / 8) * (pg / esz) : tot / esz;
      if (pg == 65536) m_base[k] = ((a >> 4) * 65536) + ((a % 16) << 48);
      else             m_base[k] = a * 4096;
      if (k == 0)      m_ids[k] = 64'd1 << (s_db + 1);
      else if (s_cil)  m_ids[k] = 64'd1 << (s_cb + 1);
      else             m_ids[k] = 65536;
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < 2; k++) model_clear(k);
         m_cqv = 0; m_cqb = 0; m_cqe = 0; m_done = 0;
         m_busy = 0; en_prev = 0; m_pos = 0; snap = {};
      end else begin
         bit stop;
         m_done = 0;
         if ((unit_en && !en_prev) || reload) begin
            snap = {};
            for (int i = 0; i < 8; i++) snap.push_back(base_regs[i*64 +: 64]);
            s_db = dev_id_bits; s_cb = coll_id_bits; s_cil = coll_id_limited;
            m_cqv = queue_reg[63];
            m_cqe = queue_reg[63] ? (longint'(queue_reg[7:0]) + 1) * 4096 / 32 : 0;
            m_cqb = queue_reg[63] ? longint'(queue_reg[51:12]) * 4096 : 0;
            m_busy = 1; m_pos = 0;
         end else if (m_busy) begin
            model_apply(snap[m_pos], stop);
            if (stop || m_pos == 7) begin
               m_busy = 0;
               m_done = 1;
            end else begin
               m_pos++;
            end
         end
         en_prev = unit_en;
      end
   end

   task automatic check(string tag, string what, longint unsigned got, longint unsigned exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, got, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (monitor_on && rst_n) begin
         check("R6", "dev_valid",  dev_valid,  m_valid[0]);
         check("R6", "coll_valid", coll_valid, m_valid[1]);
         check("R1", "dev_page",   dev_page_bytes,  m_pg[0]);
         check("R1", "coll_page",  coll_page_bytes, m_pg[1]);
         check(m_ind[0] != 0 ? "R3" : "R2", "dev_entries",  dev_max_entries,  m_ent[0]);
         check(m_ind[1] != 0 ? "R3" : "R2", "coll_entries", coll_max_entries, m_ent[1]);
         check("R2", "dev_esz_ind",  {dev_indirect, dev_entry_bytes},   {m_ind[0][0], m_esz[0][5:0]});
         check("R2", "coll_esz_ind", {coll_indirect, coll_entry_bytes}, {m_ind[1][0], m_esz[1][5:0]});
         check("R4", "dev_base",  dev_base,  m_base[0]);
         check("R4", "coll_base", coll_base, m_base[1]);
         check("R7", "dev_ids",   dev_max_ids,  m_ids[0]);
         check("R7", "coll_ids",  coll_max_ids, m_ids[1]);
         check("R8", "queue", {cq_valid, cq_entries, cq_base}, {m_cqv[0], m_cqe[15:0], m_cqb[51:0]});
         check("R9", "done", done, m_done);
      end
   end

   // ---------------- stimulus helpers ----------------
   function automatic logic [63:0] mk(bit v, bit ind, logic [2:0] t, logic [4:0] esz,
                                      logic [1:0] pg, logic [35:0] addr, logic [7:0] sz);
      logic [63:0] r = '0;
      r[63] = v; r[62] = ind; r[58:56] = t; r[52:48] = esz;
      r[47:12] = addr; r[9:8] = pg; r[7:0] = sz;
      return r;
   endfunction

   function automatic logic [63:0] mkq(bit v, logic [39:0] addr, logic [7:0] sz);
      logic [63:0] r = '0;
      r[63] = v; r[51:12] = addr; r[7:0] = sz;
      return r;
   endfunction

   function automatic logic [63:0] rnd_reg();
      logic [2:0] tsel [6] = '{3'd0, 3'd1, 3'd4, 3'd2, 3'd1, 3'd4};
      if ($urandom % 5 == 0) return 64'd0;
      return mk(($urandom % 8) != 0, $urandom % 2, tsel[$urandom % 6], 5'($urandom),
                2'($urandom), {$urandom, 4'($urandom)}, 8'($urandom));
   endfunction

   task automatic clear_regs();
      base_regs = '0;
   endtask

   task automatic set_reg(int i, logic [63:0] v);
      base_regs[i*64 +: 64] = v;
   endtask

   task automatic pulse_reload();
      @(negedge clk) reload = 1'b1;
      @(negedge clk) reload = 1'b0;
   endtask

   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [51:0] sv_cbase;
      logic [39:0] sv_cent;
      logic [32:0] sv_cids;
      rst_n = 1'b0; unit_en = 1'b0; reload = 1'b0;
      base_regs = '0; queue_reg = '0;
      dev_id_bits = '0; coll_id_bits = '0; coll_id_limited = 1'b0;
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(1);
      // R10: reset state
      check("R10", "reset outputs", {dev_valid, coll_valid, cq_valid, done, dev_max_entries,
            coll_base, cq_entries}, '0);
      monitor_on = 1'b1;
      wait_cyc(2);

      // Scenario A: enable rise, 64 KB flat device, 4 KB indirect collection
      set_reg(0, mk(1, 0, 3'd1, 5'd7,  2'd2, 36'hABCDEF123, 8'd3));
      set_reg(1, mk(1, 1, 3'd4, 5'd15, 2'd0, 36'h123456789, 8'd1));
      queue_reg = mkq(1, 40'h123456789A, 8'd5);
      dev_id_bits = 5'd15; coll_id_bits = 4'd7; coll_id_limited = 1'b1;
      @(negedge clk) unit_en = 1'b1;
      wait_cyc(12);
      check("R1", "64K code page", dev_page_bytes, 65536);
      check("R4", "64K split base", dev_base, 52'h3_ABCD_EF12_0000);
      check("R3", "indirect coll entries", coll_max_entries, (2 * 4096 / 8) * (4096 / 16));
      check("R7", "coll ids limited", coll_max_ids, 256);
      check("R8", "queue entries", cq_entries, 6 * 128);

      // Scenario B: reload, 16 KB indirect device, code 3 collection, no limit
      clear_regs();
      set_reg(0, mk(1, 1, 3'd1, 5'd3,  2'd1, 36'h00000ABCD, 8'd10));
      set_reg(1, mk(1, 0, 3'd4, 5'd31, 2'd3, 36'hFFFFFFFFF, 8'd255));
      queue_reg = mkq(0, 40'hFFFF, 8'd9);
      coll_id_limited = 1'b0; dev_id_bits = 5'd31;
      pulse_reload();
      wait_cyc(12);
      check("R1", "code3 page", coll_page_bytes, 65536);
      check("R7", "coll ids default", coll_max_ids, 65536);
      check("R7", "dev ids max", dev_max_ids, 33'h1_0000_0000);
      check("R8", "queue invalid", {cq_valid, cq_entries}, 0);

      // Scenario C (R5): other types and a non-zero type-0 register are ignored
      sv_cbase = coll_base; sv_cent = coll_max_entries; sv_cids = coll_max_ids;
      clear_regs();
      set_reg(0, mk(1, 0, 3'd2, 5'd1, 2'd0, 36'h1, 8'd1));
      set_reg(1, mk(0, 0, 3'd0, 5'd0, 2'd0, 36'h0, 8'd7));
      set_reg(3, mk(1, 0, 3'd1, 5'd0, 2'd0, 36'h5, 8'd0));
      set_reg(6, mk(0, 1, 3'd7, 5'd2, 2'd1, 36'h9, 8'd2));
      pulse_reload();
      wait_cyc(12);
      check("R5", "coll unchanged", {coll_base, coll_max_entries, coll_max_ids},
            {sv_cbase, sv_cent, sv_cids});
      check("R5", "dev from reg3", dev_max_entries, 4096);

      // Scenario D (R6): invalid collection at index 2 stops the pass
      clear_regs();
      set_reg(0, mk(1, 0, 3'd1, 5'd7, 2'd1, 36'h777, 8'd0));
      set_reg(2, mk(0, 0, 3'd4, 5'd7, 2'd0, 36'h1, 8'd0));
      set_reg(5, mk(1, 0, 3'd1, 5'd7, 2'd2, 36'h2, 8'd0));
      pulse_reload();
      wait_cyc(2);
      check("R6", "done not yet", done, 0);
      wait_cyc(1);
      check("R6", "early done after index 2", done, 1);
      wait_cyc(8);
      check("R6", "coll zeroed", {coll_valid, coll_max_entries}, 0);
      check("R6", "later dev reg skipped", dev_page_bytes, 16384);

      // Scenario E (R9): held enable does not retrigger; a new rise does
      clear_regs();
      set_reg(7, mk(1, 0, 3'd4, 5'd1, 2'd0, 36'h42, 8'd2));
      wait_cyc(12);
      check("R9", "held enable no pass", coll_valid, 0);
      @(negedge clk) unit_en = 1'b0;
      @(negedge clk) unit_en = 1'b1;
      wait_cyc(9);
      check("R9", "full pass done", done, 1);
      wait_cyc(2);

      // Scenario F: random configurations with restarts mid-pass
      for (int it = 0; it < 60; it++) begin
         for (int i = 0; i < 8; i++) set_reg(i, rnd_reg());
         queue_reg = mkq($urandom % 3 != 0, {$urandom, 8'($urandom)}, 8'($urandom));
         dev_id_bits = 5'($urandom); coll_id_bits = 4'($urandom);
         coll_id_limited = 1'($urandom);
         pulse_reload();
         wait_cyc(1 + $urandom % 12);
      end
      wait_cyc(12);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule